// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the timing strobes for a UART from a base clock. Each base-clock cycle first goes to a fractional pre-scaler. The pre-scaler is set by a multiplier `mul` and an add-divisor `dadd`, and on average it lets `mul` of every `mul + dadd` cycles through. The cycles that pass are then counted down by a 16-bit integer divisor `DL`. Each time that count completes, the block emits a one-cycle sample tick at 16 times the bit rate. Every sixteenth sample tick is also flagged as a bit-rate tick. The resulting bit rate is Fbase · mul / (mul + dadd) / (16 · DL).

Software programs the block through a byte-wide write port. The divisor bytes can only be written while a latch-access bit is set in a line-control byte. The fractional byte can be written at any time. New settings are taken up only when the divisor counter reloads, so a tick period that has already started is never cut short or stretched. The reset value of `rst_n` is applied asynchronously, and its release is expected to be synchronised upstream.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted both ticks are low. After release, with the reset settings (divisor 0, fractional byte 0x10), a sample tick appears on every base-clock cycle.
- R2: When the fractional stage is bypassed because `dadd` is 0, consecutive sample ticks are exactly DL base cycles apart.
- R3: With a legal setting (1 ≤ mul ≤ 15, 1 ≤ dadd < mul), sample tick n and sample tick n+mul are exactly DL·(mul+dadd) base cycles apart, once the setting has been in force for a few ticks.
- R4: With a legal fractional setting, a swallowed base cycle is always followed by a passed one while the setting stays unchanged.
- R5: An illegal fractional setting (mul = 0, or dadd ≥ mul) bypasses the fractional stage. The tick spacing is then DL cycles.
- R6: The bit tick is high only together with a sample tick, and on every sixteenth sample tick. The first bit tick after reset coincides with the 16th sample tick.
- R7: A divisor of 0 behaves as a divisor of 1. The divisor counter never holds zero.
- R8: The register map is: address 0 holds the divisor low byte, address 1 the divisor high byte, address 2 the fractional byte (dadd in bits 3:0, mul in bits 7:4), and address 3 the line-control byte, whose bit 7 is the latch-access bit. Writes to addresses 0 and 1 are ignored while bit 7 is clear. Address 2 is writable at all times.
- R9: Register writes take effect only at the next reload of the divisor counter. The tick period in progress completes with the old divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| sample_tick | output | 1 | One-cycle strobe at 16x the bit rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate, coincident with a sample tick |

## Verification
If the phase accumulator held a wrong value, some base cycles would be swallowed in the wrong place. The span of `mul` consecutive sample ticks would then drift from DL·(mul+dadd) within one such span, and the bit-tick span would be off by the same amount sixteen times over. A divisor counter that loaded from the wrong source or at the wrong moment would show up in the first tick interval after a write, which is measured against the old divisor. A corrupted sub-tick counter would move the first bit tick away from the sixteenth sample tick after reset.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int ADDR_W = 2;
  localparam int FRAC_W = 4;
  localparam int LCA_BIT = 7;

  localparam logic [ADDR_W-1:0] ADR_FRAC = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_LCR  = 2'd3;

  typedef struct packed {
    logic [FRAC_W-1:0] mul;
    logic [FRAC_W-1:0] dadd;
  } frac_cfg_t;

  localparam frac_cfg_t FRAC_RST = '{mul: 4'd1, dadd: 4'd0};
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DL_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              reload,
  output logic [DL_W-1:0]   dl_load,
  output frac_cfg_t         frac_act
);
  localparam int NB = DL_W / DATA_W;

  logic      lca_q, lca_d;
  frac_cfg_t frac_sh_q, frac_sh_d;
  frac_cfg_t frac_act_q, frac_act_d;

  // divisor bytes: byte i lives at address i, gated by the latch-access bit
  for (genvar i = 0; i < NB; i++) begin : g_dl_byte
    logic [DATA_W-1:0] byte_q, byte_d;
    always_comb begin
      byte_d = byte_q;
      if (wr_en && lca_q && (wr_addr == ADDR_W'(i))) byte_d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end
    assign dl_load[i*DATA_W +: DATA_W] = byte_q;
  end

  always_comb begin
    lca_d      = lca_q;
    frac_sh_d  = frac_sh_q;
    frac_act_d = frac_act_q;
    if (wr_en && wr_addr == ADR_LCR)  lca_d = wr_data[LCA_BIT];
    if (wr_en && wr_addr == ADR_FRAC) frac_sh_d = frac_cfg_t'(wr_data[2*FRAC_W-1:0]);
    if (reload) frac_act_d = frac_sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lca_q      <= 1'b0;
      frac_sh_q  <= FRAC_RST;
      frac_act_q <= FRAC_RST;
    end else begin
      lca_q      <= lca_d;
      frac_sh_q  <= frac_sh_d;
      frac_act_q <= frac_act_d;
    end
  end

  assign frac_act = frac_act_q;

  // R8: a divisor write with the access bit clear leaves the divisor untouched
  a_r8_latch_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lca_q && wr_addr < ADDR_W'(NB)) |=> $stable(dl_load));
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import baud_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  frac_cfg_t cfg,
  output logic      pass
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, diff;
  logic [ACC_W-1:0] mul_x, dadd_x;
  logic             legal, bypass;

  assign mul_x  = {1'b0, cfg.mul};
  assign dadd_x = {1'b0, cfg.dadd};
  assign legal  = (cfg.mul != '0) && (cfg.dadd < cfg.mul);
  assign bypass = !legal || (cfg.dadd == '0);
  assign diff   = acc_q - mul_x;

  always_comb begin
    pass  = 1'b1;
    acc_d = acc_q;
    if (bypass) begin
      acc_d = '0;
    end else if (acc_q >= mul_x) begin
      pass  = 1'b0;
      acc_d = (diff >= mul_x) ? '0 : diff;
    end else begin
      acc_d = acc_q + dadd_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R4: swallowed cycles never come back to back under a steady setting
  a_r4_no_double_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    !pass |=> (pass || !$stable(cfg.mul) || !$stable(cfg.dadd)));
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DL_W = 16,
  parameter int OVS  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pass,
  input  logic [DL_W-1:0] dl,
  output logic            reload,
  output logic            sample_tick,
  output logic            bit_tick
);
  localparam int SUB_W = $clog2(OVS);

  logic [DL_W-1:0]  cnt_q, cnt_d, dl_eff;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             stk_q, btk_q, stk_d, btk_d;

  assign dl_eff = (dl == '0) ? DL_W'(1) : dl;
  assign reload = pass && (cnt_q == DL_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    sub_d = sub_q;
    stk_d = 1'b0;
    btk_d = 1'b0;
    if (reload) begin
      cnt_d = dl_eff;
      stk_d = 1'b1;
      btk_d = (sub_q == SUB_W'(OVS - 1));
      sub_d = (sub_q == SUB_W'(OVS - 1)) ? '0 : sub_q + 1'b1;
    end else if (pass) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= DL_W'(1);
      sub_q <= '0;
      stk_q <= 1'b0;
      btk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sub_q <= sub_d;
      stk_q <= stk_d;
      btk_q <= btk_d;
    end
  end

  assign sample_tick = stk_q;
  assign bit_tick    = btk_q;

  // R7: the counter never rests at zero
  a_r7_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);
  // R6: a bit tick always rides on a sample tick
  a_r6_bit_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);
  // R2: no tick without a reload decision on the previous cycle
  a_r2_tick_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> !sample_tick);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DL_W   = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  logic [DL_W-1:0] dl_load;
  frac_cfg_t       frac_act;
  logic            pass, reload;

  baud_regs #(.DATA_W(DATA_W), .DL_W(DL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload(reload), .dl_load(dl_load), .frac_act(frac_act)
  );

  frac_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .cfg(frac_act), .pass(pass)
  );

  tick_divider #(.DL_W(DL_W), .OVS(OVS)) u_div (
    .clk(clk), .rst_n(rst_n), .pass(pass), .dl(dl_load), .reload(reload),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sample_tick, bit_tick;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // cycles from one tick to the k-th following tick
  task automatic span_of(input bit use_bit, input int k, output int span);
    int t0;
    int n;
    do @(negedge clk); while (!(use_bit ? bit_tick : sample_tick));
    t0 = cyc;
    n = 0;
    while (n < k) begin
      @(negedge clk);
      if (use_bit ? bit_tick : sample_tick) n++;
    end
    span = cyc - t0;
  endtask

  task automatic cfg(input int dl, input int m, input int d);
    int s;
    wr(2'd3, 8'h80);
    wr(2'd0, 8'(dl));
    wr(2'd1, 8'(dl >> 8));
    wr(2'd3, 8'h00);
    wr(2'd2, 8'((m << 4) | d));
    span_of(1'b0, 3, s);
  endtask

  function automatic bit legal(input int m, input int d);
    return (m != 0) && (d < m);
  endfunction
  function automatic int dl_eff(input int dl);
    return (dl == 0) ? 1 : dl;
  endfunction

  // R3/R5/R2: expected span of eff_m sample ticks (and bit ticks x16)
  task automatic check_cfg(input string req, input int dl, input int m, input int d);
    int em, ed, s;
    em = legal(m, d) ? m : 1;
    ed = legal(m, d) ? d : 0;
    span_of(1'b0, em, s);
    chk(req, s, dl_eff(dl) * (em + ed));
    span_of(1'b1, em, s);
    chk({req, " R6 bit"}, s, 16 * dl_eff(dl) * (em + ed));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s, n, t0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset sample", int'(sample_tick), 0);
    chk("R1 reset bit", int'(bit_tick), 0);
    rst_n = 1'b1;
    // R6: first bit tick on 16th sample tick
    n = 0;
    do begin
      @(negedge clk);
      if (sample_tick) n++;
    end while (!bit_tick && n < 40);
    chk("R6 first bit tick", n, 16);
    span_of(1'b0, 1, s);
    chk("R1 default every cycle", s, 1);

    cfg(0, 1, 0);  check_cfg("R7 zero divisor", 0, 1, 0);
    cfg(6, 3, 0);  check_cfg("R2 integer", 6, 3, 0);
    cfg(3, 5, 2);  check_cfg("R3 fractional", 3, 5, 2);
    cfg(2, 15, 14); check_cfg("R3 max fraction", 2, 15, 14);
    cfg(4, 0, 3);  check_cfg("R5 mul zero", 4, 0, 3);
    cfg(5, 4, 6);  check_cfg("R5 dadd over mul", 5, 4, 6);

    // R8: divisor writes ignored while access bit clear
    cfg(7, 1, 0);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'd3);
    span_of(1'b0, 3, s);
    span_of(1'b0, 1, s);
    chk("R8 gated divisor", s, 7);

    // R9: period in progress finishes with the old divisor
    cfg(40, 1, 0);
    do @(negedge clk); while (!sample_tick);
    t0 = cyc;
    wr(2'd3, 8'h80);
    wr(2'd0, 8'd5);
    wr(2'd3, 8'h00);
    do @(negedge clk); while (!sample_tick);
    chk("R9 old period kept", cyc - t0, 40);
    span_of(1'b0, 1, s);
    chk("R9 new period", s, 5);

    for (int i = 0; i < 12; i++) begin
      int dl, m, d;
      dl = $urandom_range(0, 5);
      m  = $urandom_range(0, 15);
      d  = $urandom_range(0, 15);
      cfg(dl, m, d);
      check_cfg(legal(m, d) && d != 0 ? "R3 random" : "R5 random", dl, m, d);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule